// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block keeps the setup of a frequency synthesizer: a 9-bit feedback multiplier M, a 2-bit output divider code, and a spread-spectrum enable flag. It can be written through either of two paths that share the same registers. The first is a parallel path: nine pins are copied into M while a parallel strobe is low, and the value is frozen when that strobe goes high. The second is a serial path: with the parallel strobe high, a slow serial clock shifts a frame in, and a serial strobe moves the frame into the registers.

Every control pin and the serial data pin pass through a two-stage synchronizer into the single system clock domain. Edges of the serial clock and the serial strobe are found there. The block drives the active M value, the output divide ratio as a one-hot number (1, 2, 4 or 8), the spread-spectrum flag, and a flag that shows whether M lies in the range in which the loop can lock.

Top module: `synth_cfg_loader`

## Requirements
- R1: While reset is asserted, M is 200, the divide ratio is 2, spread-spectrum is off and the range flag is 1. Because the parallel strobe synchronizer resets low, the parallel pins are copied into M for the first cycles after release.
- R2: While the synchronized parallel strobe is low, M takes the value on the parallel pins at every clock edge. A pin change shows on `m_o` one rising edge later.
- R3: While the parallel strobe is low, the divide ratio is forced to 2.
- R4: Once the parallel strobe is high, later changes on the parallel pins have no effect on M.
- R5: A serial frame is 14 bits, most significant first: two null slots, the spread-spectrum bit, divider code bit 1, divider code bit 0, then M bit 8 down to M bit 0. A rising edge of the serial strobe while the parallel strobe is high copies the last 12 bits shifted into the registers.
- R6: While the serial strobe is held high with the parallel strobe high, each rising edge of the serial clock updates M, the divider code and the spread-spectrum bit from the shifted contents.
- R7: After the serial strobe falls, further serial clocking does not change the outputs until the next rising edge of the serial strobe.
- R8: Divider code 00 gives ratio 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R9: The range flag is 1 exactly when M is between 125 and 350 inclusive.
- R10: The values in the two null slots never reach any output.
- R11: Serial clock edges that arrive while the parallel strobe is low shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| par_m_i | input | 9 | Parallel M value |
| par_strobe_i | input | 1 | Parallel strobe: low means copy the pins, high means hold |
| ser_clk_i | input | 1 | Serial shift clock, sampled as data |
| ser_data_i | input | 1 | Serial frame data |
| ser_strobe_i | input | 1 | Serial strobe: a rise loads the registers, held high it follows the shifts |
| m_o | output | 9 | Active feedback multiplier M |
| div_ratio_o | output | 4 | Output divide ratio: 1, 2, 4 or 8 |
| ssc_o | output | 1 | Spread-spectrum enable |
| m_ok_o | output | 1 | M lies within the lock range |

## Verification
A change on a strobe, the serial clock or serial data reaches the registers on the third rising edge after the change: two synchronizer stages, then the registered action. A change on the parallel pins reaches them on the first edge. The ratio and the range flag follow the registers in the same cycle. The bench drives inputs on falling edges and waits at least five edges after any synchronized change before sampling. It checks pin pass-through on the falling edge that directly follows one rising edge, so a wrong latency on either path misses the sample.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int PAY_W   = 1 + N_W + M_W;   // stored part of a serial frame
  localparam int FRAME_W = PAY_W + 2;       // two null slots lead the frame
  localparam int RATIO_W = 1 << N_W;

  localparam logic [N_W-1:0] N_DIV2 = 2'b01;

  // field order matches the order of the stored payload bits
  typedef struct packed {
    logic           ssc;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/sync_vec.sv
module sync_vec #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-W-1:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/rise_det.sv
module rise_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign rise_o[b] = lvl_i[b] & ~prev_q[b];
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign nxt_o = sh_d;

  // R5
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> sh_q[0] == $past(bit_i));

  // R11
  no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(sh_q));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import synth_cfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_RST = 9'd200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_mode_i,
  input  logic [M_W-1:0]   par_m_i,
  input  logic             xfer_i,
  input  logic [PAY_W-1:0] pay_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q, cfg_d;
  cfg_t pay;

  assign pay = cfg_t'(pay_i);

  always_comb begin
    cfg_d = cfg_q;
    if (par_mode_i) begin
      cfg_d.m = par_m_i;
      cfg_d.n = N_DIV2;
    end else if (xfer_i) begin
      cfg_d = pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.m   <= M_RST;
      cfg_q.n   <= N_DIV2;
      cfg_q.ssc <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R2
  par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode_i |=> cfg_q.m == $past(par_m_i));

  // R3
  par_div2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode_i |=> cfg_q.n == N_DIV2);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode_i && !xfer_i) |=> $stable(cfg_q));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter logic [M_W-1:0] M_MIN       = 9'd125,
  parameter logic [M_W-1:0] M_MAX       = 9'd350,
  parameter logic [M_W-1:0] M_RST       = 9'd200,
  parameter int             SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [M_W-1:0]     par_m_i,
  input  logic               par_strobe_i,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_strobe_i,
  output logic [M_W-1:0]     m_o,
  output logic [RATIO_W-1:0] div_ratio_o,
  output logic               ssc_o,
  output logic               m_ok_o
);
  localparam int NCTL = 4;
  localparam int I_PS = 0, I_SC = 1, I_SS = 2, I_SD = 3;

  logic [NCTL-1:0]  raw, lvl;
  logic [1:0]       rise;    // [0] serial clock, [1] serial strobe
  logic             par_mode, shift_en, xfer;
  logic [PAY_W-1:0] pay_nxt;
  cfg_t             cfg;

  assign raw[I_PS] = par_strobe_i;
  assign raw[I_SC] = ser_clk_i;
  assign raw[I_SS] = ser_strobe_i;
  assign raw[I_SD] = ser_data_i;

  sync_vec #(.W(NCTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(lvl)
  );

  rise_det #(.W(2)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl_i({lvl[I_SS], lvl[I_SC]}), .rise_o(rise)
  );

  assign par_mode = ~lvl[I_PS];
  assign shift_en = lvl[I_PS] & rise[0];
  assign xfer     = lvl[I_PS] & (rise[1] | (lvl[I_SS] & rise[0]));

  frame_shifter #(.W(PAY_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en_i(shift_en),
    .bit_i(lvl[I_SD]), .nxt_o(pay_nxt)
  );

  cfg_bank #(.M_RST(M_RST)) u_bank (
    .clk(clk), .rst_n(rst_n), .par_mode_i(par_mode), .par_m_i(par_m_i),
    .xfer_i(xfer), .pay_i(pay_nxt), .cfg_o(cfg)
  );

  assign m_o         = cfg.m;
  assign ssc_o       = cfg.ssc;
  assign div_ratio_o = RATIO_W'(1) << cfg.n;
  assign m_ok_o      = (cfg.m >= M_MIN) && (cfg.m <= M_MAX);

  // R8
  ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_ratio_o) == 1);

  // R7
  strobe_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[I_PS] && !lvl[I_SS] && !rise[1]) |=> $stable(m_o) && $stable(ssc_o));
endmodule

// File: tb/tb_synth_cfg_loader.sv
module tb_synth_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] par_m;
  logic       par_strobe, ser_clk, ser_data, ser_strobe;
  logic [8:0] m_o;
  logic [3:0] div_ratio_o;
  logic       ssc_o, m_ok_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  synth_cfg_loader dut (
    .clk(clk), .rst_n(rst_n), .par_m_i(par_m), .par_strobe_i(par_strobe),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_strobe_i(ser_strobe),
    .m_o(m_o), .div_ratio_o(div_ratio_o), .ssc_o(ssc_o), .m_ok_o(m_ok_o)
  );

  // {frame[13:0] = nulls, ssc, n1, n0, m[8:0]; expected ratio[3:0]; expected range flag}
  localparam logic [18:0] VEC [6] = '{
    {2'b00, 1'b1, 2'b00, 9'd125, 4'd1, 1'b1},
    {2'b11, 1'b0, 2'b01, 9'd350, 4'd2, 1'b1},
    {2'b10, 1'b1, 2'b10, 9'd124, 4'd4, 1'b0},
    {2'b01, 1'b0, 2'b11, 9'd351, 4'd8, 1'b0},
    {2'b00, 1'b1, 2'b11, 9'd511, 4'd8, 1'b0},
    {2'b11, 1'b0, 2'b10, 9'd200, 4'd4, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_data = b;
    ser_clk  = 1'b1;
    wait_neg(5);
    ser_clk  = 1'b0;
    wait_neg(5);
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk);
    ser_strobe = 1'b1;
    wait_neg(6);
    ser_strobe = 1'b0;
    wait_neg(6);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] sh;
    rst_n = 1'b0; par_m = 9'd300; par_strobe = 1'b0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_strobe = 1'b0;
    wait_neg(3);
    // R1 reset state
    chk("R1 m", m_o, 200);
    chk("R1 ratio", div_ratio_o, 2);
    chk("R1 ssc", ssc_o, 0);
    chk("R1 ok", m_ok_o, 1);
    rst_n = 1'b1;
    wait_neg(2);
    chk("R1 pins copied after release", m_o, 300);

    // R11: serial clocking while parallel strobe low is ignored; register stays clear
    send_frame(14'h3fff);
    @(negedge clk); par_strobe = 1'b1;
    wait_neg(6);
    pulse_load();
    chk("R11 m", m_o, 0);
    chk("R11 ratio", div_ratio_o, 1);
    chk("R11 ssc", ssc_o, 0);
    chk("R9 ok at 0", m_ok_o, 0);

    // R5 R8 R9 R10: table of serial frames
    for (int v = 0; v < 6; v++) begin
      send_frame(VEC[v][18:5]);
      pulse_load();
      chk("R5 m", m_o, int'(VEC[v][13:5]));
      chk("R5 ssc", ssc_o, int'(VEC[v][16]));
      chk("R8 ratio", div_ratio_o, int'(VEC[v][4:1]));
      chk("R9 ok", m_ok_o, int'(VEC[v][0]));
    end

    // R6: serial strobe held high follows each shift
    sh = VEC[5][16:5];
    @(negedge clk); ser_strobe = 1'b1;
    wait_neg(6);
    chk("R6 reload same", m_o, 200);
    begin
      logic [13:0] f;
      f = {2'b00, 1'b1, 2'b10, 9'd300};
      for (int i = 13; i >= 0; i--) begin
        send_bit(f[i]);
        sh = {sh[10:0], f[i]};
        chk("R6 m follows shift", m_o, int'(sh[8:0]));
      end
    end
    chk("R6 ratio", div_ratio_o, 4);
    chk("R6 ssc", ssc_o, 1);

    // R7: after strobe falls, shifting leaves outputs alone
    @(negedge clk); ser_strobe = 1'b0;
    wait_neg(6);
    send_frame({2'b11, 1'b0, 2'b00, 9'd5});
    chk("R7 m held", m_o, 300);
    chk("R7 ratio held", div_ratio_o, 4);
    chk("R7 ssc held", ssc_o, 1);
    pulse_load();
    chk("R7 m after reload", m_o, 5);
    chk("R7 ratio after reload", div_ratio_o, 1);
    chk("R10 ssc not from nulls", ssc_o, 0);

    // R2 R3: parallel pass-through
    @(negedge clk); par_m = 9'd150; par_strobe = 1'b0;
    wait_neg(6);
    chk("R2 m", m_o, 150);
    chk("R3 ratio forced 2", div_ratio_o, 2);
    par_m = 9'd333;
    @(negedge clk);
    chk("R2 one-edge latency", m_o, 333);
    chk("R9 ok 333", m_ok_o, 1);

    // R4: latch on strobe high
    par_strobe = 1'b1;
    wait_neg(6);
    par_m = 9'd17;
    wait_neg(6);
    chk("R4 m latched", m_o, 333);
    chk("R4 ratio", div_ratio_o, 2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule